// File: doc/BRIEF.md
# ADC Background Calibration Sequencer

This block is the digital controller for calibrating a successive-approximation converter. It does not touch the analog parts. It keeps one offset correction and one correction for each weighted capacitor bit in a small on-block table. It fills that table by asking an analog front end to measure the residual error of one table entry at a time. Each answer nudges the entry one code closer to zero error. Every state change is qualified by a clock enable that comes from the converter prescaler. The enable rate must stay at or below the maximum converter clock, 2 MHz, for the start-up calibration to be valid.

The start-up phase begins by itself when reset is released. It runs a fixed number of rounds. Each round interleaves an offset step with a step on each capacitor bit in turn. A conversion request takes priority over the next calibration step. While the conversion runs, the phase is parked. Afterwards it continues from the very step it would have taken next, so conversions lengthen the start-up phase but never reorder it.

Once the start-up phase is over, the block stops calibrating on its own. It then runs exactly one check-and-correct step after each conversion. These steps alternate between the offset entry and the bit entries, and the bit entries are taken in turn. Software has no control over any of this. The conversion path only reads the table.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset is released, the block starts measurement steps with no outside action. During reset, `cal_done`, `conv_busy` and `meas_valid` are low and every table entry reads 0.
- R2: The start-up phase has 2*NB*ROUNDS steps. Step k (counting from 0) measures entry 0 (offset) when k is even. When k is odd, it measures entry 1+((k/2) mod NB), the capacitor bit (k/2) mod NB.
- R3: `conv_req_ready` is high only while no step and no conversion is under way. A pending request is taken ahead of the next calibration step. A step already in flight is finished first. After the conversion, the step order continues unchanged.
- R4: An accepted conversion keeps `conv_busy` high for exactly CONV_TICKS enabled edges. `conv_done` is then high for one clock cycle. `meas_valid` is never high while `conv_busy` is high.
- R5: Measurement uses valid/ready. `meas_valid` and `meas_idx` stay constant until a clock edge where `clk_en` and `meas_ready` are both high. `meas_err` is sampled on that edge.
- R6: On a transfer, the addressed entry goes up by one if `meas_err` > 0, goes down by one if it is < 0, and is unchanged if it is 0. Entries are CW-bit two's complement values that saturate at +31 and -32 for CW=6.
- R7: `cal_done` rises on the edge that completes the last start-up step. It stays high until the next reset.
- R8: After `cal_done`, each conversion is followed by exactly one step, and no step happens without a conversion. These steps alternate between offset and bit entries, starting with offset and then bit 0. The bit entries advance round-robin.
- R9: `cal_rd_data` shows, combinationally, entry `cal_rd_idx`: 0 is the offset and 1..NB are the bits. An index above NB reads 0.
- R10: While `clk_en` is low, no handshake is taken and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Prescaler enable qualifying every state change |
| conv_req_valid | input | 1 | Conversion request |
| conv_req_ready | output | 1 | Request can be taken |
| conv_busy | output | 1 | Conversion window open |
| conv_done | output | 1 | One-cycle end-of-conversion pulse |
| meas_valid | output | 1 | Measurement request to the front end |
| meas_ready | input | 1 | Front end returns its error now |
| meas_idx | output | $clog2(NB+1) | Table entry being measured |
| meas_err | input | EW | Signed residual error |
| cal_rd_idx | input | $clog2(NB+1) | Table read index for the conversion path |
| cal_rd_data | output | CW | Signed correction at that index |
| cal_done | output | 1 | Start-up phase complete |

## Verification
The bench's analog stub holds a target value for every entry. It returns the target minus its own estimate of the stored value, and it withholds `meas_ready` in an irregular pattern. This checks that the step order and the one-code update hold under back-pressure. Some targets lie inside the range and some lie beyond both limits, which separates normal convergence from saturation. Conversions are injected at different points of the start-up phase, including back to back, and the enable is frozen for a window. A design that restarted, skipped or reordered steps would then break the expected entry sequence. After start-up the targets are shifted, and single conversions must each pull one step in the alternating order.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_MEAS = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_cal_order.sv
// Step-order generator: offset/bit toggle, bit round-robin pointer and
// start-up round counter. The same toggle and pointer continue after start-up.
module adc_cal_order #(
  parameter int NB     = 8,
  parameter int ROUNDS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       bg,
  output logic [$clog2(NB+1)-1:0]    idx,
  output logic                       last_rst
);
  localparam int IW = $clog2(NB+1);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [BW-1:0] BLAST = BW'(NB-1);
  localparam logic [RW-1:0] RLAST = RW'(ROUNDS-1);

  logic          lin;
  logic [BW-1:0] bptr;
  logic [RW-1:0] rnd;

  assign idx      = lin ? (IW'(bptr) + IW'(1)) : '0;
  assign last_rst = lin && (bptr == BLAST) && (rnd == RLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin  <= 1'b0;
      bptr <= '0;
      rnd  <= '0;
    end else if (adv) begin
      lin <= ~lin;
      if (lin) begin
        if (bptr == BLAST) begin
          bptr <= '0;
          if (!bg && rnd != RLAST) rnd <= rnd + RW'(1);
        end else begin
          bptr <= bptr + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adc_cal_ram.sv
// Correction table: entry 0 offset, entries 1..NB capacitor bits.
module adc_cal_ram #(
  parameter int NB = 8,
  parameter int CW = 6,
  parameter int EW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NB+1)-1:0]  wr_idx,
  input  logic signed [EW-1:0]     err,
  input  logic [$clog2(NB+1)-1:0]  rd_idx,
  output logic signed [CW-1:0]     rd_data
);
  localparam int NE = NB + 1;
  localparam int IW = $clog2(NB+1);
  localparam logic [CW-1:0] VMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] VMIN = {1'b1, {(CW-1){1'b0}}};

  logic [NE-1:0][CW-1:0] mem;
  logic [NE-1:0][CW-1:0] nxt;
  logic                  err_pos;
  logic                  err_neg;

  assign err_neg = err[EW-1];
  assign err_pos = !err[EW-1] && (|err);

  for (genvar g = 0; g < NE; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_comb begin
      nxt[g] = mem[g];
      if (hit && err_pos && mem[g] != VMAX) nxt[g] = mem[g] + CW'(1);
      if (hit && err_neg && mem[g] != VMIN) nxt[g] = mem[g] - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem <= '0;
    else        mem <= nxt;
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < NE) rd_data = mem[rd_idx];
  end
endmodule

// File: rtl/adc_cal_ctrl.sv
// Sequencer: conversion has priority at idle; start-up steps run on their
// own, background steps follow each conversion.
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int CONV_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic conv_req_valid,
  output logic conv_req_ready,
  output logic conv_busy,
  output logic conv_done,
  output logic meas_valid,
  input  logic meas_ready,
  input  logic last_rst,
  output logic cal_done,
  output logic step_adv
);
  localparam int CTW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  localparam logic [CTW-1:0] CLAST = CTW'(CONV_TICKS-1);

  seq_state_t     state;
  logic [CTW-1:0] cnt;

  assign conv_req_ready = (state == ST_IDLE);
  assign conv_busy      = (state == ST_CONV);
  assign meas_valid     = (state == ST_MEAS);
  assign step_adv       = clk_en && meas_valid && meas_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cal_done  <= 1'b0;
      conv_done <= 1'b0;
    end else begin
      conv_done <= clk_en && (state == ST_CONV) && (cnt == CLAST);
      if (clk_en) begin
        unique case (state)
          ST_IDLE: begin
            if (conv_req_valid) begin
              state <= ST_CONV;
              cnt   <= '0;
            end else if (!cal_done) begin
              state <= ST_MEAS;
            end
          end
          ST_CONV: begin
            if (cnt == CLAST) state <= cal_done ? ST_MEAS : ST_IDLE;
            else              cnt   <= cnt + CTW'(1);
          end
          ST_MEAS: begin
            if (meas_ready) begin
              state <= ST_IDLE;
              if (!cal_done && last_rst) cal_done <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int NB         = 8,
  parameter int CW         = 6,
  parameter int EW         = 8,
  parameter int ROUNDS     = 32,
  parameter int CONV_TICKS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     conv_req_valid,
  output logic                     conv_req_ready,
  output logic                     conv_busy,
  output logic                     conv_done,
  output logic                     meas_valid,
  input  logic                     meas_ready,
  output logic [$clog2(NB+1)-1:0]  meas_idx,
  input  logic signed [EW-1:0]     meas_err,
  input  logic [$clog2(NB+1)-1:0]  cal_rd_idx,
  output logic signed [CW-1:0]     cal_rd_data,
  output logic                     cal_done
);
  localparam int IW = $clog2(NB+1);

  logic step_adv;
  logic last_rst;

  adc_cal_ctrl #(.CONV_TICKS(CONV_TICKS)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .clk_en         (clk_en),
    .conv_req_valid (conv_req_valid),
    .conv_req_ready (conv_req_ready),
    .conv_busy      (conv_busy),
    .conv_done      (conv_done),
    .meas_valid     (meas_valid),
    .meas_ready     (meas_ready),
    .last_rst       (last_rst),
    .cal_done       (cal_done),
    .step_adv       (step_adv)
  );

  adc_cal_order #(.NB(NB), .ROUNDS(ROUNDS)) u_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (step_adv),
    .bg       (cal_done),
    .idx      (meas_idx),
    .last_rst (last_rst)
  );

  adc_cal_ram #(.NB(NB), .CW(CW), .EW(EW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (step_adv),
    .wr_idx  (meas_idx),
    .err     (meas_err),
    .rd_idx  (cal_rd_idx),
    .rd_data (cal_rd_data)
  );
endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          conv_req_ready,
  input logic          conv_busy,
  input logic          conv_done,
  input logic          meas_valid,
  input logic          meas_ready,
  input logic [IW-1:0] meas_idx,
  input logic          cal_done
);
  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid && !(clk_en && meas_ready) |=> meas_valid && $stable(meas_idx));

  a_r4_no_meas_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_valid && conv_busy));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(meas_valid) && $stable(conv_busy) && $stable(cal_done));

  a_r3_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_ready |-> !meas_valid && !conv_busy);

  a_r8_step_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done && $rose(meas_valid) |-> $past(conv_busy));
endmodule

bind adc_cal_seq adc_cal_chk #(.IW(IW)) u_chk (.*);

// File: tb/sim_adc_cal_seq.sv
module sim_adc_cal_seq;
  localparam int NB = 8, CW = 6, EW = 8, ROUNDS = 32, T = 8;
  localparam int IW = $clog2(NB+1);
  localparam int NSTART = 2*NB*ROUNDS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic conv_req_valid = 1'b0;
  logic conv_req_ready, conv_busy, conv_done, meas_valid, cal_done;
  logic meas_ready = 1'b0;
  logic [IW-1:0] meas_idx;
  logic signed [EW-1:0] meas_err;
  logic [IW-1:0] cal_rd_idx = '0;
  logic signed [CW-1:0] cal_rd_data;

  always #2.5 clk = ~clk;

  adc_cal_seq u0 (.*);

  int checks = 0, errors = 0;
  int tgt[NB+1];
  int mdl[NB+1];
  int exp_q[$];
  int nsteps = 0, n_acc = 0, n_done = 0, busy_ticks = 0, cyc = 0;
  bit freeze = 0, conv_pend = 0, upd_pend = 0, done_seen = 0, finished = 0;
  int p_idx, p_err;
  bit bg_lin = 0;
  int bg_bit = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    return (v > 31) ? 31 : (v < -32) ? -32 : v;
  endfunction

  // stub: error is target minus the bench's own estimate of the stored entry
  always_comb begin
    int i;
    i = int'(meas_idx);
    meas_err = (i <= NB) ? EW'(tgt[i] - mdl[i]) : '0;
  end

  // driver tasks: push expected entry order into the scoreboard
  task automatic push_startup();
    for (int r = 0; r < ROUNDS; r++)
      for (int b = 0; b < NB; b++) begin
        exp_q.push_back(0);
        exp_q.push_back(b + 1);
      end
  endtask

  task automatic push_bg();
    exp_q.push_back(bg_lin ? bg_bit + 1 : 0);
    if (bg_lin) bg_bit = (bg_bit + 1) % NB;
    bg_lin = !bg_lin;
  endtask

  // negedge process: drive enable/ready, monitor handshakes (scoreboard)
  always @(negedge clk) begin
    cyc++;
    if (upd_pend) begin
      if (p_err > 0 && mdl[p_idx] < 31) mdl[p_idx]++;
      if (p_err < 0 && mdl[p_idx] > -32) mdl[p_idx]--;
      upd_pend = 0;
    end
    if (conv_pend) begin conv_req_valid = 0; conv_pend = 0; end
    if (conv_done) begin
      n_done++;
      chk(busy_ticks == T, "R4 conv length", busy_ticks, T);
      busy_ticks = 0;
    end
    if (cal_done && !done_seen) begin
      done_seen = 1;
      chk(nsteps == NSTART, "R7 cal_done at last step", nsteps, NSTART);
    end
    clk_en = !freeze && (cyc % 2 == 0);
    meas_ready = ((cyc * 7) % 5) != 1;
    if (conv_busy && clk_en) busy_ticks++;
    if (clk_en && conv_req_valid && conv_req_ready) begin conv_pend = 1; n_acc++; end
    if (clk_en && meas_valid && meas_ready) begin
      p_idx = int'(meas_idx);
      p_err = int'(meas_err);
      upd_pend = 1;
      nsteps++;
      if (exp_q.size() == 0) chk(0, "R2/R8 unexpected step", p_idx, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(p_idx == e, cal_done ? "R8 step order" : "R2 R3 step order", p_idx, e);
      end
    end
  end

  task automatic do_conv();
    int a0, d0;
    a0 = n_acc; d0 = n_done;
    @(negedge clk); #1 conv_req_valid = 1;
    wait (n_acc != a0);
    wait (n_done != d0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", nsteps, NSTART);
    finish_run();
  end

  initial begin
    int s0, mv;
    tgt = '{5, -7, 12, 40, -45, 0, 31, -32, 3};
    foreach (mdl[i]) mdl[i] = 0;
    push_startup();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!cal_done && !conv_busy && !meas_valid, "R1 reset outputs", int'(cal_done), 0);
    for (int i = 0; i <= NB; i++) begin
      cal_rd_idx = IW'(i); #1;
      chk(cal_rd_data == 0, "R1 reset entry", int'(cal_rd_data), 0);
    end
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(nsteps > 0, "R1 autonomous start", nsteps, 1);
    // R3 conversions mid start-up, including back to back
    wait (nsteps >= 40); do_conv(); do_conv();
    wait (nsteps >= 201); do_conv();
    chk(!cal_done, "R3 start-up still running", int'(cal_done), 0);
    // R10 enable freeze
    wait (nsteps >= 300);
    @(negedge clk); #1 freeze = 1;
    @(negedge clk); #1 s0 = nsteps; mv = int'(meas_valid);
    repeat (40) @(negedge clk);
    chk(nsteps == s0, "R10 no step while disabled", nsteps, s0);
    chk(int'(meas_valid) == mv, "R10 request frozen", int'(meas_valid), mv);
    #1 freeze = 0;
    wait (cal_done);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 start-up steps consumed", exp_q.size(), 0);
    // R6 R9 convergence and saturation
    for (int i = 0; i <= NB; i++) begin
      cal_rd_idx = IW'(i); #1;
      chk(int'(cal_rd_data) == clampv(tgt[i]), "R6 R9 converged entry", int'(cal_rd_data), clampv(tgt[i]));
    end
    cal_rd_idx = IW'(NB + 1); #1;
    chk(cal_rd_data == 0, "R9 out of range", int'(cal_rd_data), 0);
    // R8 background: no step without conversion
    s0 = nsteps;
    repeat (100) @(negedge clk);
    chk(nsteps == s0, "R8 idle without conversion", nsteps, s0);
    chk(cal_done, "R7 sticky", int'(cal_done), 1);
    tgt[0] = 9; tgt[1] = -5; tgt[2] = 14; tgt[3] = 20;
    for (int k = 0; k < 8; k++) begin
      s0 = nsteps;
      push_bg();
      do_conv();
      wait (nsteps == s0 + 1);
      repeat (6) @(negedge clk);
      chk(nsteps == s0 + 1, "R8 one step per conversion", nsteps, s0 + 1);
    end
    chk(exp_q.size() == 0, "R8 background order consumed", exp_q.size(), 0);
    for (int i = 0; i <= NB; i++) begin
      cal_rd_idx = IW'(i); #1;
      chk(int'(cal_rd_data) == mdl[i], "R6 background update", int'(cal_rd_data), mdl[i]);
    end
    finish_run();
  end
endmodule